// File: doc/BRIEF.md
# Receive-buffer status calendar generator

This block sits on the receive side of a packet interface. It tells the far-end transmitter, two bits at a time, how full each port's receive buffer is. Every port brings a fill level. Two shared watermarks sort each level into one of three classes: starving, hungry or satisfied. The block then walks a programmable list of port numbers and puts one 2-bit word on the status channel per status clock. Each word reports the class of the port that the current calendar slot names.

Each pass through the list is a sequence. A sequence begins with a framing word and ends with a 2-bit parity word taken over the slot words of that sequence, so one sequence takes the list length plus two status clocks. The list may name a port several times, which reports busy ports more often. Software rewrites list entries and the list length through a simple write port. The new settings are held in a shadow copy and are picked up only when the next framing word goes out, so a sequence in flight is never altered.

Top module: `sc_status_cal`

## Requirements
- R1: While reset is asserted, `stat_o` is 2'b11. After reset the calendar length equals NPORT and slot i names port i mod NPORT.
- R2: After reset the output repeats a sequence of length+2 words, one word per clock. It starts with the framing word 2'b11, sends one word per calendar slot in slot order, and ends with the parity word.
- R3: A slot word is 2'b00 (starving) when the port's level is at or below `wm_starve_i`. It is 2'b01 (hungry) when the level is above `wm_starve_i` and at or below `wm_hungry_i`. Otherwise it is 2'b10 (satisfied). A slot word is never 2'b11.
- R4: When a level is at or below both watermarks, the word is starving, even if `wm_hungry_i` is below `wm_starve_i`.
- R5: The parity word is the bitwise XOR of all slot words in the same sequence.
- R6: A slot word reflects the levels and watermarks present at the clock edge that puts that word on `stat_o`, not earlier values.
- R7: A write with `cfg_slot_wr_i` high stores `cfg_port_i` into calendar slot `cfg_slot_i`. A port may appear in any number of slots.
- R8: Slot and length writes take effect from the first sequence whose framing word is emitted on a later clock edge than the write. A write on the same edge as a framing word waits for the following sequence.
- R9: A length write with a value below NPORT or above CAL_DEPTH is ignored, and the previous length stays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_i | input | NPORT*LVL_W | Fill levels; port p occupies bits [p*LVL_W +: LVL_W] |
| wm_starve_i | input | LVL_W | Starving watermark |
| wm_hungry_i | input | LVL_W | Hungry watermark |
| cfg_slot_wr_i | input | 1 | Write one calendar slot |
| cfg_slot_i | input | SLOT_W | Slot index to write |
| cfg_port_i | input | PORT_W | Port number for that slot |
| cfg_len_wr_i | input | 1 | Write calendar length |
| cfg_len_i | input | LEN_W | New calendar length |
| stat_o | output | 2 | Status channel word |

## Verification
The bench uses the default build: NPORT=4, CAL_DEPTH=8 and LVL_W=6. This makes the whole level range 0..63 and every slot index cheap to sweep. The bench drives each port with a level that changes every clock and steps both watermarks through a 4x4 grid that includes reversed pairs. It reprograms the calendar to non-linear orders and to every length from 3 to 9, so both illegal ends of the length range are exercised. Writes land on arbitrary clock edges, including the edges that emit a framing word. A cycle-by-cycle model computes each expected word arithmetically from the requirements.

// File: rtl/sc_pkg.sv
package sc_pkg;
   typedef enum logic [1:0] {
      ST_STARVE = 2'b00,
      ST_HUNGRY = 2'b01,
      ST_SATIS  = 2'b10,
      ST_FRAME  = 2'b11
   } stat_e;
endpackage

// File: rtl/sc_classify.sv
module sc_classify #(
   parameter int LVL_W = 6
) (
   input  logic [LVL_W-1:0] lvl_i,
   input  logic [LVL_W-1:0] wm_starve_i,
   input  logic [LVL_W-1:0] wm_hungry_i,
   output sc_pkg::stat_e    code_o
);
   // starving is tested first so it wins whatever the watermark order
   always_comb begin
      if (lvl_i <= wm_starve_i)      code_o = sc_pkg::ST_STARVE;
      else if (lvl_i <= wm_hungry_i) code_o = sc_pkg::ST_HUNGRY;
      else                           code_o = sc_pkg::ST_SATIS;
   end
endmodule

// File: rtl/sc_cal_store.sv
module sc_cal_store #(
   parameter int NPORT     = 4,
   parameter int CAL_DEPTH = 8,
   localparam int PORT_W   = $clog2(NPORT),
   localparam int SLOT_W   = $clog2(CAL_DEPTH),
   localparam int LEN_W    = $clog2(CAL_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_slot_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic [PORT_W-1:0] port_i,
   input  logic              wr_len_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              commit_i,
   input  logic [SLOT_W-1:0] rd_idx_i,
   output logic [PORT_W-1:0] rd_port_o,
   output logic [LEN_W-1:0]  act_len_o
);
   logic [PORT_W-1:0] shd_cal [CAL_DEPTH];
   logic [PORT_W-1:0] act_cal [CAL_DEPTH];
   logic [LEN_W-1:0]  shd_len, act_len;
   logic              port_ok, len_ok;

   generate
      if ((1 << PORT_W) == NPORT) begin : g_port_full
         assign port_ok = 1'b1;
      end else begin : g_port_cmp
         assign port_ok = (int'(port_i) < NPORT);
      end
   endgenerate

   assign len_ok = (int'(len_i) >= NPORT) && (int'(len_i) <= CAL_DEPTH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < CAL_DEPTH; i++) begin
            shd_cal[i] <= PORT_W'(i % NPORT);
            act_cal[i] <= PORT_W'(i % NPORT);
         end
         shd_len <= LEN_W'(NPORT);
         act_len <= LEN_W'(NPORT);
      end else begin
         if (commit_i) begin
            act_cal <= shd_cal;
            act_len <= shd_len;
         end
         if (wr_slot_i && port_ok) shd_cal[slot_i] <= port_i;
         if (wr_len_i && len_ok)   shd_len <= len_i;
      end
   end

   assign rd_port_o = act_cal[rd_idx_i];
   assign act_len_o = act_len;

   AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(act_len) >= NPORT) && (int'(act_len) <= CAL_DEPTH)); // R9
   AST_COMMIT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_len) |-> $past(commit_i)); // R8
endmodule

// File: rtl/sc_status_cal.sv
module sc_status_cal #(
   parameter int NPORT     = 4,
   parameter int CAL_DEPTH = 8,
   parameter int LVL_W     = 6,
   localparam int PORT_W   = $clog2(NPORT),
   localparam int SLOT_W   = $clog2(CAL_DEPTH),
   localparam int LEN_W    = $clog2(CAL_DEPTH + 1),
   localparam int POS_W    = $clog2(CAL_DEPTH + 2)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPORT*LVL_W-1:0] lvl_i,
   input  logic [LVL_W-1:0]       wm_starve_i,
   input  logic [LVL_W-1:0]       wm_hungry_i,
   input  logic                   cfg_slot_wr_i,
   input  logic [SLOT_W-1:0]      cfg_slot_i,
   input  logic [PORT_W-1:0]      cfg_port_i,
   input  logic                   cfg_len_wr_i,
   input  logic [LEN_W-1:0]       cfg_len_i,
   output logic [1:0]             stat_o
);
   generate
      if (NPORT < 2) begin : g_bad_nport
         $error("sc_status_cal: NPORT must be at least 2");
      end
      if (CAL_DEPTH < NPORT) begin : g_bad_depth
         $error("sc_status_cal: CAL_DEPTH must be at least NPORT");
      end
      if (LVL_W < 1) begin : g_bad_lvl
         $error("sc_status_cal: LVL_W must be positive");
      end
   endgenerate

   sc_pkg::stat_e     codes [NPORT];
   logic [POS_W-1:0]  pos;
   logic [POS_W-1:0]  last_pos;
   logic [SLOT_W-1:0] rd_idx;
   logic [PORT_W-1:0] rd_port;
   logic [LEN_W-1:0]  act_len;
   logic [1:0]        dip_acc;
   logic              commit;

   genvar p;
   generate
      for (p = 0; p < NPORT; p++) begin : g_cls
         sc_classify #(.LVL_W(LVL_W)) u_cls (
            .lvl_i       (lvl_i[p*LVL_W +: LVL_W]),
            .wm_starve_i (wm_starve_i),
            .wm_hungry_i (wm_hungry_i),
            .code_o      (codes[p])
         );
      end
   endgenerate

   assign commit   = (pos == '0);
   assign rd_idx   = SLOT_W'(pos - POS_W'(1));
   assign last_pos = POS_W'(act_len) + POS_W'(1);

   sc_cal_store #(.NPORT(NPORT), .CAL_DEPTH(CAL_DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_slot_i (cfg_slot_wr_i),
      .slot_i    (cfg_slot_i),
      .port_i    (cfg_port_i),
      .wr_len_i  (cfg_len_wr_i),
      .len_i     (cfg_len_i),
      .commit_i  (commit),
      .rd_idx_i  (rd_idx),
      .rd_port_o (rd_port),
      .act_len_o (act_len)
   );

   // pos: 0 framing next, 1..len slot next, len+1 parity next
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos     <= '0;
         dip_acc <= 2'b00;
         stat_o  <= sc_pkg::ST_FRAME;
      end else if (commit) begin
         stat_o  <= sc_pkg::ST_FRAME;
         dip_acc <= 2'b00;
         pos     <= POS_W'(1);
      end else if (pos == last_pos) begin
         stat_o  <= dip_acc;
         pos     <= '0;
      end else begin
         stat_o  <= codes[rd_port];
         dip_acc <= dip_acc ^ codes[rd_port];
         pos     <= pos + POS_W'(1);
      end
   end

   AST_FRAME_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == POS_W'(1)) |-> (stat_o == sc_pkg::ST_FRAME)); // R2
   AST_SLOT_NOT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (pos >= POS_W'(2) && pos <= last_pos) |-> (stat_o != sc_pkg::ST_FRAME)); // R3
   AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= last_pos); // R2
endmodule

// File: tb/sc_status_cal_bench.sv
module sc_status_cal_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NPORT = 4;
   localparam int CAL_DEPTH = 8;
   localparam int LVL_W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NPORT*LVL_W-1:0] lvl_flat;
   logic [LVL_W-1:0] lv [NPORT];
   logic [LVL_W-1:0] wm_s = '0, wm_h = '0;
   logic slot_wr = 1'b0, len_wr = 1'b0;
   logic [2:0] slot_sel = '0;
   logic [1:0] port_sel = '0;
   logic [3:0] len_val = '0;
   logic [1:0] stat_o;

   int checks = 0, errors = 0;
   bit mon_en = 1'b0;

   int m_shd [CAL_DEPTH];
   int m_act [CAL_DEPTH];
   int m_slen, m_alen, mpos;
   logic [1:0] mdip;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb for (int p = 0; p < NPORT; p++) lvl_flat[p*LVL_W +: LVL_W] = lv[p];

   sc_status_cal #(.NPORT(NPORT), .CAL_DEPTH(CAL_DEPTH), .LVL_W(LVL_W)) u_sc_status_cal (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_flat),
      .wm_starve_i(wm_s), .wm_hungry_i(wm_h),
      .cfg_slot_wr_i(slot_wr), .cfg_slot_i(slot_sel), .cfg_port_i(port_sel),
      .cfg_len_wr_i(len_wr), .cfg_len_i(len_val), .stat_o(stat_o));

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] cls(int l, int s, int h);
      if (l <= s) return 2'b00; // R4 starving first
      if (l <= h) return 2'b01;
      return 2'b10;
   endfunction

   // model: words observed at a falling edge come from the rising edge just before it
   always @(negedge clk) if (mon_en) begin
      if (mpos == 0) begin
         chk("R2 R8 framing word", stat_o, 2'b11);
         for (int i = 0; i < CAL_DEPTH; i++) m_act[i] = m_shd[i];
         m_alen = m_slen;
         mdip = 2'b00;
         mpos = 1;
      end else if (mpos <= m_alen) begin
         logic [1:0] e;
         e = cls(int'(lv[m_act[mpos-1]]), int'(wm_s), int'(wm_h));
         chk("R1 R3 R4 R6 R7 R8 slot word", stat_o, e);
         mdip = mdip ^ e;
         mpos++;
      end else begin
         chk("R5 parity word", stat_o, mdip);
         mpos = 0;
      end
      if (slot_wr) m_shd[slot_sel] = int'(port_sel);
      if (len_wr && int'(len_val) >= NPORT && int'(len_val) <= CAL_DEPTH) m_slen = int'(len_val); // R9
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic sweep_lv(int c, int a, int b);
      for (int p = 0; p < NPORT; p++) lv[p] = LVL_W'((c * a + p * b) % 64);
   endtask

   initial begin
      for (int p = 0; p < NPORT; p++) lv[p] = '0;
      for (int i = 0; i < CAL_DEPTH; i++) m_shd[i] = i % NPORT;
      m_slen = NPORT; m_alen = NPORT; mpos = 0; mdip = 2'b00;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R1 reset output", stat_o, 2'b11);
      end
      #1; rst_n = 1'b1; mon_en = 1'b1;
      // R1 R3 R6: default linear calendar, fixed watermarks, levels moving each clock
      wm_s = 6'd10; wm_h = 6'd30;
      for (int c = 0; c < 200; c++) begin tick(); sweep_lv(c, 7, 13); end
      // R3 R4: watermark grid including reversed pairs
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++) begin
            wm_s = LVL_W'(a * 21); wm_h = LVL_W'(b * 21);
            for (int c = 0; c < 24; c++) begin tick(); sweep_lv(c + a * 3, 5, 17); end
         end
      wm_s = 6'd12; wm_h = 6'd40;
      // R7 R8: non-linear calendar written mid-sequence
      for (int i = 0; i < 7; i++) begin
         tick(); slot_wr = 1'b1; slot_sel = 3'(i);
         port_sel = 2'((i % 2 == 0) ? 0 : (i == 3) ? 2 : (i == 5) ? 3 : 1);
         sweep_lv(i, 9, 11);
      end
      tick(); slot_wr = 1'b0; len_wr = 1'b1; len_val = 4'd7;
      tick(); len_wr = 1'b0;
      for (int c = 0; c < 120; c++) begin tick(); sweep_lv(c, 3, 23); end
      // R9: out-of-range lengths are dropped
      for (int j = 0; j < 4; j++) begin
         tick(); len_wr = 1'b1;
         len_val = (j == 0) ? 4'd3 : (j == 1) ? 4'd9 : (j == 2) ? 4'd0 : 4'd15;
         tick(); len_wr = 1'b0;
         for (int c = 0; c < 20; c++) begin tick(); sweep_lv(c + j, 11, 7); end
      end
      tick(); len_wr = 1'b1; len_val = 4'd8;
      tick(); len_wr = 1'b0;
      for (int c = 0; c < 40; c++) begin tick(); sweep_lv(c, 13, 5); end
      // R8 R9: writes on every edge, including framing edges
      for (int c = 0; c < 150; c++) begin
         tick();
         slot_wr = 1'b1; slot_sel = 3'(c % 8); port_sel = 2'((c * 3) % 4);
         len_wr = (c % 5 == 0); len_val = 4'(3 + (c / 5) % 7);
         sweep_lv(c, 17, 29);
      end
      tick(); slot_wr = 1'b0; len_wr = 1'b0;
      for (int c = 0; c < 30; c++) begin tick(); sweep_lv(c, 19, 3); end
      @(negedge clk); #1;
      mon_en = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule